// File: doc/BRIEF.md
# Frame Synchronisation Pulse Generator

This block gives a host a timing reference for writing frames to a panel without tearing. It watches two ticks from the scan timing logic. A line tick arrives once per line period. A frame tick arrives on the line where the back porch begins. The block counts lines inside each frame and counts frames between pulses. It raises `sync_pulse` for one whole line period on a chosen line, and only in every Nth frame.

Software sets the block up through a small write-only register port with two words. The control word holds an enable bit and a 3-bit interval code. The position word holds a 9-bit line offset, counted from the frame tick. New interval and position values are held in shadow registers and are copied into use on the next frame tick, so a frame never sees a half-applied setting. Enabling the block rearms the frame counter, so the first pulse lands in the first frame that begins after the enable write.

Top module: `frame_sync_gen`

## Requirements
- R1: While the enable bit is 0, `sync_pulse` is low. Writing the enable bit to 0 drives the output low in the cycle after the write edge, even in the middle of a pulse.
- R2: Interval code 000 pulses every frame, 001 every 2nd frame, 011 every 4th frame and 101 every 6th frame. Frames are counted from the first frame after enabling, and that frame pulses.
- R3: Interval codes 010, 100, 110 and 111 never produce a pulse.
- R4: The pulse is active high. It rises at the clock edge that samples the tick opening the target line. It falls at the edge that samples the next line or frame tick, so it covers exactly one line period.
- R5: Position 0 selects the line opened by the frame tick. Position n selects the line opened by the nth line tick after that frame tick.
- R6: Positions 0 to LINES-1 (default 375) are reachable. Any position of LINES or more never produces a pulse, including when the line count saturates at 511.
- R7: A frame that is already running when the block is enabled produces no pulse. The next frame tick starts a pulsing frame. Disabling and then re-enabling rearms the interval count.
- R8: Writes to the interval code or the position do not affect the current frame. They take effect at the next frame tick, and the interval count carries on from its current value.
- R9: After reset the enable bit, the interval code and the position are all zero and the output is low.
- R10: Register layout: address 0 holds the interval code in bits 2:0 and the enable bit in bit 3, and bits 8:4 are ignored. Address 1 holds the position in bits 8:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-cycle strobe at the start of each line |
| frame_tick | input | 1 | One-cycle strobe on the line where the back porch begins; also opens that line |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 control, 1 position |
| cfg_wdata | input | POS_W | Register write data |
| sync_pulse | output | 1 | Frame synchronisation pulse, active high |

## Verification
The bench builds the block with its default parameters: 376 lines per frame and a 9-bit position. This lets it place a pulse on line 375, the last legal slot, and try positions 376 and 511. For the 511 case it drives frames longer than 511 lines, so the saturated line counter sits on a value equal to the position. Frames for the interval and illegal-code tests are kept to a few lines each, which makes thirteen consecutive frames cheap. That is enough to see the 6-frame period repeat.

// File: rtl/fsync_pkg.sv
package fsync_pkg;

    localparam int FC_W = 3;

    localparam logic ADDR_CTRL = 1'b0;
    localparam logic ADDR_POS  = 1'b1;
    localparam int   EN_BIT    = 3;

    function automatic logic [FC_W-1:0] ivl_frames(input logic [2:0] code);
        case (code)
            3'b000:  return 3'd1;
            3'b001:  return 3'd2;
            3'b011:  return 3'd4;
            3'b101:  return 3'd6;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/fsync_cfg.sv
module fsync_cfg #(
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [POS_W-1:0] cfg_wdata,
    input  logic             frame_tick,
    output logic             en,
    output logic [2:0]       code_act,
    output logic [2:0]       code_nxt,
    output logic [POS_W-1:0] pos_act
);
    import fsync_pkg::*;

    typedef struct packed {
        logic             en;
        logic [2:0]       code_sh;
        logic [POS_W-1:0] pos_sh;
        logic [2:0]       code_act;
        logic [POS_W-1:0] pos_act;
    } cfg_st_t;

    cfg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (cfg_addr == ADDR_CTRL) begin
                st_d.en      = cfg_wdata[EN_BIT];
                st_d.code_sh = cfg_wdata[2:0];
            end else begin
                st_d.pos_sh  = cfg_wdata;
            end
        end
        if (frame_tick) begin
            st_d.code_act = st_d.code_sh;
            st_d.pos_act  = st_d.pos_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en       = st_q.en;
    assign code_act = st_q.code_act;
    assign code_nxt = st_d.code_act;
    assign pos_act  = st_q.pos_act;

    // R8
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_tick |=> ($stable(code_act) && $stable(pos_act)));

endmodule

// File: rtl/fsync_line_ctr.sv
module fsync_line_ctr #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             frame_tick,
    output logic [CNT_W-1:0] line_idx
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] idx;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_tick)
            st_d.idx = '0;
        else if (line_tick && (st_q.idx != CNT_MAX))
            st_d.idx = st_q.idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_idx = st_q.idx;

    // R5
    line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> (line_idx == '0));

    // R5
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_tick && !frame_tick && (line_idx != CNT_MAX))
            |=> (line_idx == $past(line_idx) + 1'b1));

endmodule

// File: rtl/fsync_frame_ctr.sv
module fsync_frame_ctr (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  logic                     frame_tick,
    input  logic [2:0]               code_nxt,
    output logic                     fresh,
    output logic [fsync_pkg::FC_W-1:0] fcnt
);
    import fsync_pkg::*;

    typedef struct packed {
        logic            fresh;
        logic [FC_W-1:0] cnt;
    } frm_st_t;

    frm_st_t st_d, st_q;
    logic [FC_W-1:0] period;
    logic [FC_W-1:0] cnt_inc;

    always_comb begin
        period  = ivl_frames(code_nxt);
        cnt_inc = st_q.cnt + 1'b1;
        st_d    = st_q;
        if (!en) begin
            st_d.fresh = 1'b1;
            st_d.cnt   = '0;
        end else if (frame_tick) begin
            if (st_q.fresh) begin
                st_d.fresh = 1'b0;
                st_d.cnt   = '0;
            end else if ((period == '0) || (cnt_inc >= period)) begin
                st_d.cnt   = '0;
            end else begin
                st_d.cnt   = cnt_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{fresh: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign fresh = st_q.fresh;
    assign fcnt  = st_q.cnt;

    // R2
    fcnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fcnt <= 3'd5);

    // R7
    rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> fresh);

endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
    parameter int LINES = 376,
    parameter int POS_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_tick,
    input  logic             frame_tick,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [POS_W-1:0] cfg_wdata,
    output logic             sync_pulse
);
    import fsync_pkg::*;

    localparam logic [POS_W:0] LINES_V = (POS_W+1)'(LINES);

    logic             en;
    logic [2:0]       code_act;
    logic [2:0]       code_nxt;
    logic [POS_W-1:0] pos_act;
    logic [POS_W-1:0] line_idx;
    logic             fresh;
    logic [FC_W-1:0]  fcnt;
    logic             pos_ok;
    logic             code_ok;

    fsync_cfg #(.POS_W(POS_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .frame_tick (frame_tick),
        .en         (en),
        .code_act   (code_act),
        .code_nxt   (code_nxt),
        .pos_act    (pos_act)
    );

    fsync_line_ctr #(.CNT_W(POS_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .frame_tick (frame_tick),
        .line_idx   (line_idx)
    );

    fsync_frame_ctr u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .frame_tick (frame_tick),
        .code_nxt   (code_nxt),
        .fresh      (fresh),
        .fcnt       (fcnt)
    );

    always_comb begin
        pos_ok     = ({1'b0, pos_act} < LINES_V);
        code_ok    = (ivl_frames(code_act) != '0);
        sync_pulse = en && !fresh && (fcnt == '0) && code_ok && pos_ok
                     && (line_idx == pos_act);
    end

    // R1
    pulse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && (cfg_addr == ADDR_CTRL) && !cfg_wdata[EN_BIT]) |=> !sync_pulse);

    // R4
    pulse_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_pulse) |-> $past(line_tick || frame_tick));

    // R4
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_pulse && !line_tick && !frame_tick && !cfg_wr) |=> sync_pulse);

endmodule

// File: tb/tb_frame_sync_gen.sv
`timescale 1ns/1ps
module tb_frame_sync_gen;

    localparam int LP = 3;
    localparam int NV = 8;
    localparam int NF = 13;
    localparam int V_CODE  [NV] = '{0, 1, 3, 5, 2, 7, 6, 4};
    localparam int V_POS   [NV] = '{0, 3, 5, 1, 2, 0, 1, 3};
    localparam int V_LINES [NV] = '{6, 6, 6, 5, 6, 4, 5, 6};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_tick = 1'b0;
    logic       frame_tick = 1'b0;
    logic       cfg_wr = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic       sync_pulse;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    frame_sync_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_tick  (line_tick),
        .frame_tick (frame_tick),
        .cfg_wr     (cfg_wr),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .sync_pulse (sync_pulse)
    );

    function automatic int exp_period(input int code);
        case (code)
            0: return 1;
            1: return 2;
            3: return 4;
            5: return 6;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic a, input logic [8:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic set_ctrl(input logic e, input logic [2:0] code);
        cfg_write(1'b0, {5'b0, e, code});
    endtask

    task automatic one_line(input bit first, output int hi);
        @(negedge clk);
        if (first) frame_tick = 1'b1; else line_tick = 1'b1;
        @(negedge clk);
        frame_tick = 1'b0; line_tick = 1'b0;
        hi = int'(sync_pulse);
        repeat (LP-1) begin
            @(negedge clk);
            hi += int'(sync_pulse);
        end
    endtask

    task automatic run_frame(input int nl, output int hit, output int tot);
        int h;
        hit = -1; tot = 0;
        for (int i = 0; i < nl; i++) begin
            one_line(i == 0, h);
            if (h > 0 && hit < 0) hit = i;
            tot += h;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int hit, tot, h, acc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state and defaults
        check("R9 output after reset", int'(sync_pulse), 0);
        run_frame(4, hit, tot);
        check("R9 disabled by default", tot, 0);
        set_ctrl(1'b1, 3'd0);
        for (int f = 0; f < 2; f++) begin
            run_frame(4, hit, tot);
            check("R9 default position line", hit, 0);
            check("R9 default pulse width", tot, LP);
        end

        // R10: ignored control bits
        set_ctrl(1'b0, 3'd0);
        cfg_write(1'b1, 9'd1);
        cfg_write(1'b0, 9'h1F8);
        for (int f = 0; f < 2; f++) begin
            run_frame(4, hit, tot);
            check("R10 layout hit line", hit, 1);
        end

        // Vector table: interval codes, positions, widths
        for (int v = 0; v < NV; v++) begin
            int per;
            set_ctrl(1'b0, 3'd0);
            cfg_write(1'b1, 9'(V_POS[v]));
            set_ctrl(1'b1, 3'(V_CODE[v]));
            check("R7 no pulse before first frame", int'(sync_pulse), 0);
            per = exp_period(V_CODE[v]);
            for (int f = 0; f < NF; f++) begin
                bit fire;
                fire = (per != 0) && (f % per == 0) && (V_POS[v] < V_LINES[v]);
                run_frame(V_LINES[v], hit, tot);
                if (per == 0) begin
                    check("R3 illegal code silent", tot, 0);
                end else begin
                    check("R2/R5 pulse line", hit, fire ? V_POS[v] : -1);
                    check("R2/R4 pulse width", tot, fire ? LP : 0);
                end
            end
        end

        // R1: disable in the middle of a pulse
        set_ctrl(1'b0, 3'd0);
        cfg_write(1'b1, 9'd2);
        set_ctrl(1'b1, 3'd0);
        one_line(1'b1, h);
        one_line(1'b0, h);
        one_line(1'b0, h);
        check("R4 pulse on line 2", h, LP);
        set_ctrl(1'b0, 3'd0);
        check("R1 drop on disable", int'(sync_pulse), 0);
        run_frame(6, hit, tot);
        check("R1 silent while disabled", tot, 0);

        // R7: enable in mid-frame, then rearm
        cfg_write(1'b1, 9'd3);
        set_ctrl(1'b0, 3'd3);
        one_line(1'b1, h);
        one_line(1'b0, h);
        set_ctrl(1'b1, 3'd3);
        acc = 0;
        for (int i = 0; i < 3; i++) begin
            one_line(1'b0, h);
            acc += h;
        end
        check("R7 running frame silent", acc, 0);
        run_frame(6, hit, tot);
        check("R7 first frame fires", hit, 3);
        run_frame(6, hit, tot);
        check("R7 second frame silent", hit, -1);
        set_ctrl(1'b0, 3'd3);
        set_ctrl(1'b1, 3'd3);
        run_frame(6, hit, tot);
        check("R7 rearm fires", hit, 3);

        // R8: mid-frame writes take effect at the next frame
        set_ctrl(1'b0, 3'd0);
        cfg_write(1'b1, 9'd2);
        set_ctrl(1'b1, 3'd0);
        run_frame(6, hit, tot);
        check("R8 baseline", hit, 2);
        one_line(1'b1, h);
        one_line(1'b0, h);
        cfg_write(1'b1, 9'd4);
        set_ctrl(1'b1, 3'd1);
        hit = -1;
        for (int i = 2; i < 6; i++) begin
            one_line(1'b0, h);
            if (h > 0 && hit < 0) hit = i;
        end
        check("R8 current frame keeps old position", hit, 2);
        run_frame(6, hit, tot);
        check("R8 new interval skips frame", hit, -1);
        run_frame(6, hit, tot);
        check("R8 new position used", hit, 4);

        // R6: last slot and out-of-range positions
        set_ctrl(1'b0, 3'd0);
        cfg_write(1'b1, 9'd375);
        set_ctrl(1'b1, 3'd0);
        run_frame(376, hit, tot);
        check("R6 last legal line", hit, 375);
        check("R6 last legal width", tot, LP);
        cfg_write(1'b1, 9'd376);
        run_frame(512, hit, tot);
        check("R6 position 376 silent", tot, 0);
        cfg_write(1'b1, 9'd511);
        run_frame(520, hit, tot);
        check("R6 position 511 silent", tot, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule